// File: doc/BRIEF.md
# External Request Input Unit with Interrupt and Transfer-Request Modes

This block watches a set of asynchronous external request pins, one channel per pin. Each pin is brought into the clock domain through a two-flop synchroniser. A per-channel two-bit setting then decides whether the channel reacts to a low level, a high level, a rising edge or a falling edge. An event sets a sticky per-channel event flag. The flag stays set until software or the transfer handshake clears it.

Each channel works in one of two modes, selected by a per-channel mode bit:

- **Interrupt mode.** The flag, gated by an enable bit, drives that channel's interrupt request. Software drops the request by writing zero to the flag bit.
- **Transfer mode.** The flag starts a one-cycle transfer-start pulse toward an external data mover. The channel then waits for a transfer-done input, which clears the flag without raising any interrupt. For a fixed window after the start pulse, the input is ignored, which gives the requesting device time to withdraw its request. If the input is still active once the window closes, it counts as a fresh request.

A small register port gives access to the flag, enable, mode and detection settings. Writes take effect on the next clock. Reads are combinational.

Top module: `ext_req_ctrl`

## Requirements
- R1: Each pin passes through a two-flop synchroniser. A pin change driven between clock edges k-1 and k shows in the flag after clock edge k+2, and not earlier. A pulse lasting at least one clock period, and in particular one of three clocks, is always captured.
- R2: The detection setting of channel i sits at bits 2i+1:2i of the detection register. Its codes are: 00 = low level, 01 = high level, 10 = rising edge, 11 = falling edge. An edge setting raises the flag once per edge, not for as long as the level is held.
- R3: In level mode, an active level sets the flag. The flag stays set after the pin returns to its inactive level.
- R4: In interrupt mode, irq[i] is high exactly when flag i and enable i are both 1. It stays high after the pin condition has gone away, until the flag is cleared.
- R5: A register write to the flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. An event arriving in the same cycle as a clear wins, and the flag stays 1.
- R6: With the mode bit at 1 (transfer mode), a set flag produces a one-cycle pulse on xfer_start[i] and never raises irq[i]. A transfer-done pulse while the channel is waiting clears the flag.
- R7: In transfer mode, the input is ignored during the DTP_WIN clocks after the start pulse. If the input is still active after that window, the flag is set again and another start pulse follows.
- R8: Synchronous reset clears every flag, enable bit and mode bit, and sets every detection setting to rising edge (10).
- R9: Register addresses are 0 = flags, 1 = enables, 2 = modes, 3 = detection settings. Channel i occupies bit i of the first three registers. One-bit-per-channel registers read back zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NCH | Asynchronous external request pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | 2*NCH | Write data |
| rd_addr | input | 2 | Read address |
| reg_rdata | output | 2*NCH | Combinational read data |
| irq | output | NCH | Per-channel interrupt requests |
| xfer_start | output | NCH | Per-channel transfer-start pulses |
| xfer_done | input | NCH | Per-channel transfer-done inputs |

## Verification
The bench builds the block with NCH = 4, so that each channel carries a different detection code at the same time: rising edge, falling edge, low level and high level. This puts all four codes and their independence across channels within reach in one run. DTP_WIN is kept at 3. The transfer window then closes a few clocks after the start pulse, which lets the bench observe three cases with exact cycle counts: a request withdrawn inside the window, a done that lands while the window still masks the pin, and the re-request that follows once the window ends.

// File: rtl/ext_req_pkg.sv
package ext_req_pkg;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_e;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } xfer_st_e;

    typedef enum logic [1:0] {
        RA_FLAG = 2'd0,
        RA_EN   = 2'd1,
        RA_MODE = 2'd2,
        RA_DET  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } samp_t;

    function automatic logic detect_hit(det_e d, samp_t s);
        logic hit;
        case (d)
            DET_LOW:  hit = !s.cur;
            DET_HIGH: hit = s.cur;
            DET_RISE: hit = s.cur && !s.prev;
            default:  hit = !s.cur && s.prev;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ext_req_sync.sv
module ext_req_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign d_sync = stage2;
endmodule

// File: rtl/ext_req_chan.sv
module ext_req_chan
    import ext_req_pkg::*;
#(
    parameter int DTP_WIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp,
    input  det_e det,
    input  logic en,
    input  logic dtp,
    input  logic clr_wr,
    input  logic clr_bit,
    input  logic done,
    output logic flag,
    output logic irq,
    output logic start
);
    localparam int CW = $clog2(DTP_WIN + 1);

    logic          prev;
    logic [CW-1:0] win;
    xfer_st_e      st;
    samp_t         sp;
    logic          hit, masked, set_ev, clr_ev;

    assign sp     = '{cur: smp, prev: prev};
    assign hit    = detect_hit(det, sp);
    assign masked = dtp && (win != '0);
    assign set_ev = hit && !masked;
    assign clr_ev = (clr_wr && !clr_bit) || (st == XS_WAIT && done);
    assign start  = dtp && (st == XS_IDLE) && flag;
    assign irq    = flag && en && !dtp;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            flag <= 1'b0;
            win  <= '0;
            st   <= XS_IDLE;
        end else begin
            prev <= smp;
            if (set_ev)      flag <= 1'b1;
            else if (clr_ev) flag <= 1'b0;
            if (start)           win <= CW'(DTP_WIN);
            else if (win != '0)  win <= win - 1'b1;
            case (st)
                XS_IDLE: if (start) st <= XS_WAIT;
                default: if (!dtp || done) st <= XS_IDLE;
            endcase
        end
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (hit && !masked) |=> flag);
    assert_flag_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_wr && !done) |=> flag);
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);
endmodule

// File: rtl/ext_req_ctrl.sv
module ext_req_ctrl
    import ext_req_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DTP_WIN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   pin_in,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [2*NCH-1:0] reg_wdata,
    input  logic [1:0]       rd_addr,
    output logic [2*NCH-1:0] reg_rdata,
    output logic [NCH-1:0]   irq,
    output logic [NCH-1:0]   xfer_start,
    input  logic [NCH-1:0]   xfer_done
);
    localparam int DW = 2 * NCH;

    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] en_q, mode_q, flags;
    det_e           det_q [NCH];
    logic [DW-1:0]  det_flat;
    logic           flag_wr;

    assign flag_wr = reg_wr && (reg_addr == RA_FLAG);

    ext_req_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst(rst), .d_async(pin_in), .d_sync(pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (reg_wr && reg_addr == RA_EN) begin
            en_q <= reg_wdata[NCH-1:0];
        end else if (reg_wr && reg_addr == RA_MODE) begin
            mode_q <= reg_wdata[NCH-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                             det_q[i] <= DET_RISE;
            else if (reg_wr && reg_addr == RA_DET) det_q[i] <= det_e'(reg_wdata[2*i +: 2]);
        end
        assign det_flat[2*i +: 2] = det_q[i];

        ext_req_chan #(.DTP_WIN(DTP_WIN)) u_chan (
            .clk(clk), .rst(rst), .smp(pin_s[i]), .det(det_q[i]),
            .en(en_q[i]), .dtp(mode_q[i]), .clr_wr(flag_wr),
            .clr_bit(reg_wdata[i]), .done(xfer_done[i]),
            .flag(flags[i]), .irq(irq[i]), .start(xfer_start[i])
        );

        assert_dtp_quiet_R6: assert property (@(posedge clk) disable iff (rst)
            mode_q[i] |-> !irq[i]);
    end

    always_comb begin
        case (rd_addr)
            RA_FLAG: reg_rdata = {{(DW-NCH){1'b0}}, flags};
            RA_EN:   reg_rdata = {{(DW-NCH){1'b0}}, en_q};
            RA_MODE: reg_rdata = {{(DW-NCH){1'b0}}, mode_q};
            default: reg_rdata = det_flat;
        endcase
    end

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && mode_q == '0 && flags == '0 && xfer_start == '0));
endmodule

// File: tb/sim_ext_req_ctrl.sv
module sim_ext_req_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 2 * NCH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NCH-1:0] pin_in = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] reg_rdata;
    logic [NCH-1:0] irq, xfer_start;
    logic [NCH-1:0] xfer_done = '0;

    int cyc = 0;
    int checks = 0;
    int errs = 0;
    bit finished = 0;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    ext_req_ctrl #(.NCH(NCH), .DTP_WIN(3)) u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
        .reg_rdata(reg_rdata), .irq(irq), .xfer_start(xfer_start),
        .xfer_done(xfer_done)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops every expected item whose cycle has come
    always begin
        @(negedge clk);
        #1;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                logic [31:0] act;
                case (q[i].sel)
                    0:       act = 32'(irq);
                    1:       act = 32'(xfer_start);
                    default: act = 32'(reg_rdata);
                endcase
                checks++;
                if (act !== q[i].v) begin
                    errs++;
                    $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                             q[i].tag, q[i].sel, cyc, act, q[i].v);
                end
                q.delete(i);
            end
        end
    end

    task automatic exp_in(int d, int sel, logic [31:0] v, string tag);
        q.push_back('{cyc + d, sel, v, tag});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R8 / R9: reset state of every register
        exp_in(0, 2, 0, "R8 flags");
        exp_in(0, 0, 0, "R8 irq");
        step(1); rd_addr = 2'd1; exp_in(0, 2, 0, "R8 enables");
        step(1); rd_addr = 2'd2; exp_in(0, 2, 0, "R8 modes");
        step(1); rd_addr = 2'd3; exp_in(0, 2, 32'hAA, "R8 R2 det reset");
        step(1); rd_addr = 2'd0;

        // ch0 rise, ch1 fall, ch2 low, ch3 high
        wr(2'd3, 8'h4E);
        pin_in[1] = 1'b1; pin_in[2] = 1'b1;
        step(5);
        wr(2'd0, 8'h00);
        exp_in(0, 2, 0, "R5 clear all");
        wr(2'd1, 8'h0F);

        // R1: three-clock rising pulse on ch0, latency of three edges
        pin_in[0] = 1'b1;
        exp_in(2, 0, 0, "R1 not before sync");
        exp_in(3, 0, 32'h1, "R1 edge captured");
        step(3); pin_in[0] = 1'b0;
        step(4);
        exp_in(0, 0, 32'h1, "R4 irq held");
        wr(2'd0, 8'hFF);
        exp_in(0, 2, 32'h1, "R5 write one keeps");
        wr(2'd0, 8'hFE);
        exp_in(0, 2, 0, "R5 write zero clears");
        exp_in(0, 0, 0, "R4 irq drops with flag");

        // R2: held high in edge mode sets only once
        pin_in[0] = 1'b1;
        step(6);
        exp_in(0, 2, 32'h1, "R2 rise set");
        wr(2'd0, 8'hFE);
        step(3);
        exp_in(0, 2, 0, "R2 edge not level");
        pin_in[0] = 1'b0;
        step(4);
        exp_in(0, 2, 0, "R2 falling ignored in rise mode");

        // R2: falling edge on ch1
        pin_in[1] = 1'b0;
        exp_in(2, 2, 0, "R2 fall latency");
        exp_in(3, 2, 32'h2, "R2 fall captured");
        step(4); pin_in[1] = 1'b1;
        step(3);
        wr(2'd0, 8'hFD);
        exp_in(0, 2, 0, "R5 clear ch1");

        // R3: one-clock low pulse on ch2 in low-level mode
        pin_in[2] = 1'b0;
        exp_in(3, 2, 32'h4, "R3 low level set");
        step(1); pin_in[2] = 1'b1;
        step(6);
        exp_in(0, 2, 32'h4, "R3 flag sticky");
        exp_in(0, 0, 32'h4, "R4 irq sticky");
        wr(2'd0, 8'hFB);
        exp_in(0, 2, 0, "R5 clear ch2");

        // R5: set wins over clear on held high level, ch3
        pin_in[3] = 1'b1;
        step(4);
        exp_in(0, 2, 32'h8, "R3 high level set");
        wr(2'd0, 8'hF7);
        exp_in(0, 2, 32'h8, "R5 set wins");
        pin_in[3] = 1'b0;
        step(4);
        exp_in(0, 2, 32'h8, "R3 held after release");
        // R4: enable gating
        wr(2'd1, 8'h07);
        exp_in(0, 0, 0, "R4 disabled");
        exp_in(0, 2, 32'h8, "R4 flag kept while disabled");
        wr(2'd1, 8'h0F);
        exp_in(0, 0, 32'h8, "R4 re-enabled");
        wr(2'd0, 8'hF7);
        exp_in(0, 2, 0, "R5 clear ch3");

        // R6: transfer mode on ch3, request withdrawn inside window
        wr(2'd2, 8'h08);
        pin_in[3] = 1'b1;
        exp_in(3, 1, 32'h8, "R6 start pulse");
        exp_in(3, 0, 0, "R6 no irq");
        step(3);
        pin_in[3] = 1'b0;
        exp_in(1, 1, 0, "R6 single pulse");
        step(2);
        xfer_done[3] = 1'b1;
        step(1);
        xfer_done[3] = 1'b0;
        exp_in(0, 2, 0, "R6 done clears flag");
        exp_in(0, 1, 0, "R6 idle after done");
        step(3);
        exp_in(0, 1, 0, "R7 withdrawn request ignored");
        exp_in(0, 2, 0, "R7 flag stays clear");

        // R7: request held past the window re-triggers
        pin_in[3] = 1'b1;
        step(3);
        exp_in(0, 1, 32'h8, "R7 first start");
        step(2);
        xfer_done[3] = 1'b1;
        step(1);
        xfer_done[3] = 1'b0;
        exp_in(0, 2, 0, "R7 masked during window");
        exp_in(0, 1, 0, "R7 no start in window");
        step(1);
        exp_in(0, 1, 0, "R7 window end");
        step(1);
        exp_in(0, 1, 32'h8, "R7 re-request start");
        exp_in(0, 0, 0, "R6 irq quiet in transfer mode");
        pin_in[3] = 1'b0;
        step(1);
        xfer_done[3] = 1'b1;
        step(1);
        xfer_done[3] = 1'b0;
        exp_in(0, 2, 0, "R6 second done clears");
        step(4);
        exp_in(0, 1, 0, "R7 no further start");
        rd_addr = 2'd2;
        step(1);
        exp_in(0, 2, 32'h8, "R9 mode readback");
        step(3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule